// File: doc/BRIEF.md
# Arithmetic Hamming Repair Stage for a Matrix-Vector Result

This block sits behind a matrix-vector multiplier that produces twenty data results and five extra check results. Each check result is the product of the input vector with a check row, and every check row is the integer sum of a fixed group of eight matrix rows. Because multiplication by the vector is linear, a fault-free multiplier gives each check result exactly equal to the integer sum of the data results in its group. The block recomputes those five sums, compares them with the check results and turns the set of mismatching checks into a five-bit failure pattern.

Each data index belongs to a distinct, non-empty set of checks, so a single faulty data result gives a pattern that names it. The block rebuilds that result from one failing check: the check value minus the other seven members of the group. It then hands the vector downstream with flags saying whether a repair took place or the pattern could not be explained. All arithmetic is two's complement, so the repair is exact even when sums wrap.

The stage has one register, a valid/ready handshake on each side, and passes the failure pattern out with the data.

Top module: `arith_ham_fix`

## Requirements
- R1: Check membership (data index sets): check 0 = {0,5,9,12,14,15,18,19}, check 1 = {1,5,6,10,13,15,16,18}, check 2 = {2,6,7,9,11,15,16,17}, check 3 = {3,7,8,10,12,16,17,19}, check 4 = {4,8,11,13,14,17,18,19}. Data element i is bits [21*i+20 : 21*i] of `in_z`; check c is bits [24*c+23 : 24*c] of `in_s`.
- R2: Bit c of `out_syn` is 1 exactly when check value c differs from the sum, modulo 2^24, of its eight data values sign-extended to 24 bits.
- R3: With `out_syn` all zero, `out_z` equals the accepted `in_z` and both `out_fixed` and `out_bad` are 0.
- R4: When `out_syn` equals the membership column of data index i (bit c set exactly when i is in check c), element i of `out_z` is the lowest-numbered failing check value minus the other seven data values of that check, truncated to 21 bits, and `out_fixed` is 1 and `out_bad` is 0.
- R5: A pattern with only check k failing (k = 0..4) is taken as a fault on data element k and is repaired as in R4.
- R6: A non-zero pattern that matches no membership column sets `out_bad` to 1, clears `out_fixed`, and leaves `out_z` equal to the accepted `in_z`.
- R7: Only the located element is replaced; every other element of `out_z` equals its input.
- R8: `in_ready` is 1 when the output register is empty or `out_ready` is 1; a transfer accepted at a clock edge appears on the outputs with `out_valid` high immediately after that edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R11: Data values are signed 21-bit; sums use 24-bit sign extension, so extreme positive and negative data produce a zero pattern when the checks are consistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Stage can take an input |
| in_z | input | 420 | Twenty data results, 21 bits each |
| in_s | input | 120 | Five check results, 24 bits each |
| out_valid | output | 1 | Output vector present |
| out_ready | input | 1 | Downstream takes the output |
| out_z | output | 420 | Data results after repair |
| out_fixed | output | 1 | One element was rebuilt |
| out_bad | output | 1 | Pattern could not be located |
| out_syn | output | 5 | Failing-check pattern, bit c for check c |

## Verification
A wrong membership entry or a misrouted sum shows up on the first vector that uses the affected element: `out_syn` differs from the pattern the bench derives from its own check masks, one cycle after acceptance. A wrong lookup entry or a wrong repair operand shows as one element of `out_z` off from the fault-free value, or as a swapped `out_fixed`/`out_bad`, on that same cycle. A faulty hold or ready path shows as a changed output during backpressure or a lost or doubled transfer when the stall clears.

// File: rtl/ahc_pkg.sv
package ahc_pkg;

    localparam int N_DATA = 20;
    localparam int N_CHK  = 5;

    typedef logic [N_CHK-1:0] col_t;

    // Membership column of a data index: bit c set when the index is in check c.
    function automatic col_t col_of(input int idx);
        col_t v;
        case (idx)
            0:  v = 5'b00001;
            1:  v = 5'b00010;
            2:  v = 5'b00100;
            3:  v = 5'b01000;
            4:  v = 5'b10000;
            5:  v = 5'b00011;
            6:  v = 5'b00110;
            7:  v = 5'b01100;
            8:  v = 5'b11000;
            9:  v = 5'b00101;
            10: v = 5'b01010;
            11: v = 5'b10100;
            12: v = 5'b01001;
            13: v = 5'b10010;
            14: v = 5'b10001;
            15: v = 5'b00111;
            16: v = 5'b01110;
            17: v = 5'b11100;
            18: v = 5'b10011;
            19: v = 5'b11001;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic in_chk(input int idx, input int c);
        col_t v;
        v = col_of(idx);
        return v[c];
    endfunction

    // Lowest-numbered check that covers a data index; used for the rebuild.
    function automatic int low_chk(input int idx);
        for (int c = 0; c < N_CHK; c++) begin
            if (in_chk(idx, c)) return c;
        end
        return 0;
    endfunction

endpackage

// File: rtl/ahc_syndrome.sv
module ahc_syndrome
    import ahc_pkg::*;
#(
    parameter int DATA_W = 21,
    parameter int CHK_W  = 24
) (
    input  logic [N_DATA*DATA_W-1:0] z_flat,
    input  logic [N_CHK*CHK_W-1:0]   s_flat,
    output logic [N_CHK*CHK_W-1:0]   sum_flat,
    output logic [N_CHK-1:0]         fail
);
    localparam int EXT_W = CHK_W - DATA_W;

    logic [CHK_W-1:0] ext [N_DATA];

    for (genvar i = 0; i < N_DATA; i++) begin : g_ext
        assign ext[i] = {{EXT_W{z_flat[i*DATA_W+DATA_W-1]}}, z_flat[i*DATA_W +: DATA_W]};
    end

    for (genvar c = 0; c < N_CHK; c++) begin : g_chk
        logic [CHK_W-1:0] acc_d;
        always_comb begin
            acc_d = '0;
            for (int i = 0; i < N_DATA; i++) begin
                if (in_chk(i, c)) acc_d = acc_d + ext[i];
            end
        end
        assign sum_flat[c*CHK_W +: CHK_W] = acc_d;
        assign fail[c] = (s_flat[c*CHK_W +: CHK_W] != acc_d);
    end

endmodule

// File: rtl/ahc_locate.sv
module ahc_locate
    import ahc_pkg::*;
(
    input  logic [N_CHK-1:0]  syn,
    output logic [N_DATA-1:0] hit,
    output logic              unmatched
);
    for (genvar i = 0; i < N_DATA; i++) begin : g_col
        assign hit[i] = (syn == col_of(i));
    end

    assign unmatched = (syn != '0) && (hit == '0);

endmodule

// File: rtl/ahc_repair.sv
module ahc_repair
    import ahc_pkg::*;
#(
    parameter int DATA_W = 21,
    parameter int CHK_W  = 24
) (
    input  logic [N_DATA*DATA_W-1:0] z_flat,
    input  logic [N_CHK*CHK_W-1:0]   s_flat,
    input  logic [N_CHK*CHK_W-1:0]   sum_flat,
    input  logic [N_DATA-1:0]        hit,
    output logic [N_DATA*DATA_W-1:0] fixed_flat
);
    localparam int EXT_W = CHK_W - DATA_W;

    for (genvar i = 0; i < N_DATA; i++) begin : g_fix
        localparam int LC = low_chk(i);
        logic [CHK_W-1:0]  ext_w;
        logic [CHK_W-1:0]  others_w;
        logic [CHK_W-1:0]  rebuilt_w;
        logic [DATA_W-1:0] orig_w;

        assign orig_w    = z_flat[i*DATA_W +: DATA_W];
        assign ext_w     = {{EXT_W{orig_w[DATA_W-1]}}, orig_w};
        assign others_w  = sum_flat[LC*CHK_W +: CHK_W] - ext_w;
        assign rebuilt_w = s_flat[LC*CHK_W +: CHK_W] - others_w;

        // Two-way select: rebuilt value for the located index, input otherwise.
        assign fixed_flat[i*DATA_W +: DATA_W] = hit[i] ? rebuilt_w[DATA_W-1:0] : orig_w;
    end

endmodule

// File: rtl/arith_ham_fix.sv
module arith_ham_fix
    import ahc_pkg::*;
#(
    parameter int DATA_W = 21,
    parameter int CHK_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [N_DATA*DATA_W-1:0] in_z,
    input  logic [N_CHK*CHK_W-1:0]   in_s,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [N_DATA*DATA_W-1:0] out_z,
    output logic                     out_fixed,
    output logic                     out_bad,
    output logic [N_CHK-1:0]         out_syn
);
    localparam int VEC_W = N_DATA * DATA_W;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] z;
        logic [N_CHK-1:0] syn;
        logic             fixed;
        logic             bad;
    } stage_t;

    stage_t st_d, st_q;

    logic [N_CHK*CHK_W-1:0] sum_w;
    logic [N_CHK-1:0]       fail_w;
    logic [N_DATA-1:0]      hit_w;
    logic                   unmatched_w;
    logic [VEC_W-1:0]       fixed_w;

    ahc_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
        .z_flat   (in_z),
        .s_flat   (in_s),
        .sum_flat (sum_w),
        .fail     (fail_w)
    );

    ahc_locate u_loc (
        .syn       (fail_w),
        .hit       (hit_w),
        .unmatched (unmatched_w)
    );

    ahc_repair #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_rep (
        .z_flat     (in_z),
        .s_flat     (in_s),
        .sum_flat   (sum_w),
        .hit        (hit_w),
        .fixed_flat (fixed_w)
    );

    assign in_ready = !st_q.vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (in_ready) begin
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.z     = fixed_w;
                st_d.syn   = fail_w;
                st_d.fixed = |hit_w;
                st_d.bad   = unmatched_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_z     = st_q.z;
    assign out_syn   = st_q.syn;
    assign out_fixed = st_q.fixed;
    assign out_bad   = st_q.bad;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_z) && $stable(out_syn)
        && $stable(out_fixed) && $stable(out_bad)); // R9
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R8
    AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_syn == '0 |-> !out_fixed && !out_bad); // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_fixed && out_bad)); // R6
    AST_SINGLE_CHK_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $onehot(out_syn) |-> out_fixed); // R5

endmodule

// File: tb/sim_arith_ham_fix.sv
module sim_arith_ham_fix;
    localparam int DW = 21;
    localparam int CW = 24;
    localparam int ND = 20;
    localparam int NC = 5;
    localparam int NT = 10;

    // Bench-side membership masks, bit i = data index i in that check (R1).
    localparam logic [ND-1:0] CM [NC] = '{20'hCD221, 20'h5A462, 20'h38AC4, 20'hB1588, 20'hE6910};

    // kind: 0 clean, 1 data fault, 2 check fault
    localparam int T_KIND  [NT] = '{0, 1, 1, 1, 1, 1, 1, 2, 2, 0};
    localparam int T_IDX   [NT] = '{0, 8, 0, 4, 15, 19, 7, 0, 0, 0};
    localparam int T_DELTA [NT] = '{0, 5, -3, 1000, -1, 12345, 1048576, 0, 0, 0};
    localparam int T_SMASK [NT] = '{0, 0, 0, 0, 0, 0, 0, 11, 31, 0};
    localparam int T_SEED  [NT] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, -1};

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic in_ready;
    logic [ND*DW-1:0] in_z = '0;
    logic [NC*CW-1:0] in_s = '0;
    logic out_valid;
    logic out_ready = 1;
    logic [ND*DW-1:0] out_z;
    logic out_fixed, out_bad;
    logic [NC-1:0] out_syn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [DW-1:0] zc [ND];
    logic [DW-1:0] zi [ND];
    logic [DW-1:0] ze [ND];
    logic [CW-1:0] sc [NC];
    logic [CW-1:0] si [NC];

    always #5 clk = ~clk;

    arith_ham_fix u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_z(in_z), .in_s(in_s), .out_valid(out_valid), .out_ready(out_ready),
        .out_z(out_z), .out_fixed(out_fixed), .out_bad(out_bad), .out_syn(out_syn)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_vec(input string tag);
        int bad_i;
        bad_i = -1;
        for (int i = 0; i < ND; i++) begin
            if (bad_i < 0 && out_z[i*DW +: DW] != ze[i]) bad_i = i;
        end
        if (bad_i < 0) chk(1, tag, 0, 0);
        else chk(0, $sformatf("%s elem %0d", tag, bad_i),
                 longint'(out_z[bad_i*DW +: DW]), longint'(ze[bad_i]));
    endtask

    function automatic logic [NC-1:0] col_bench(input int idx);
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = CM[c][idx];
        return v;
    endfunction

    task automatic make_clean(input int seed);
        for (int i = 0; i < ND; i++) begin
            if (seed < 0) zc[i] = (i % 2 == 0) ? 21'h0FFFFF : 21'h100000;
            else zc[i] = DW'(seed * 40503 + i * 69069 + i * i * 977);
        end
        for (int c = 0; c < NC; c++) begin
            sc[c] = '0;
            for (int i = 0; i < ND; i++)
                if (CM[c][i]) sc[c] = sc[c] + {{(CW-DW){zc[i][DW-1]}}, zc[i]};
        end
        zi = zc; si = sc; ze = zc;
    endtask

    task automatic load_inputs();
        for (int i = 0; i < ND; i++) in_z[i*DW +: DW] = zi[i];
        for (int c = 0; c < NC; c++) in_s[c*CW +: CW] = si[c];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [NC-1:0] esyn;
        bit efix, ebad;
        // R10: reset state
        #2;
        chk(out_valid == 0, "R10 out_valid in reset", longint'(out_valid), 0);
        chk(in_ready == 1, "R10 in_ready in reset", longint'(in_ready), 1);
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R10 out_valid after reset", longint'(out_valid), 0);
        chk(in_ready == 1, "R10 in_ready after reset", longint'(in_ready), 1);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R11
        for (int n = 0; n < NT; n++) begin
            make_clean(T_SEED[n]);
            esyn = '0; efix = 0; ebad = 0;
            if (T_KIND[n] == 1) begin
                zi[T_IDX[n]] = zi[T_IDX[n]] + DW'(T_DELTA[n]);
                esyn = col_bench(T_IDX[n]);
                efix = 1;
            end else if (T_KIND[n] == 2) begin
                for (int c = 0; c < NC; c++)
                    if (T_SMASK[n][c]) si[c] = si[c] + 24'd7;
                esyn = NC'(T_SMASK[n]);
                ebad = 1;
                ze = zi;
            end
            load_inputs();
            in_valid = 1;
            @(negedge clk);
            in_valid = 0;
            chk(out_valid == 1, $sformatf("R8 vec %0d valid", n), longint'(out_valid), 1);
            chk(out_syn == esyn, $sformatf("R2 R1 vec %0d syndrome", n), longint'(out_syn), longint'(esyn));
            chk(out_fixed == efix, $sformatf("R4 R5 vec %0d fixed flag", n), longint'(out_fixed), longint'(efix));
            chk(out_bad == ebad, $sformatf("R6 vec %0d bad flag", n), longint'(out_bad), longint'(ebad));
            chk_vec($sformatf("R3 R4 R7 R11 vec %0d data", n));
        end
        @(negedge clk);
        chk(out_valid == 0, "R8 empty after drain", longint'(out_valid), 0);

        // Backpressure: R8 R9
        out_ready = 0;
        make_clean(11);
        zi[12] = zi[12] + 21'd99;
        load_inputs();
        in_valid = 1;
        @(negedge clk);
        chk(in_ready == 0, "R8 in_ready low when full and stalled", longint'(in_ready), 0);
        make_clean(12);
        zi[3] = zi[3] - 21'd1;
        load_inputs();
        repeat (3) @(negedge clk);
        make_clean(11);
        chk(out_valid == 1, "R9 valid held", longint'(out_valid), 1);
        chk(out_syn == col_bench(12), "R9 syndrome held", longint'(out_syn), longint'(col_bench(12)));
        chk_vec("R9 data held");
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        make_clean(12);
        chk(out_valid == 1, "R8 second item valid", longint'(out_valid), 1);
        chk(out_syn == 5'b01000, "R5 second item syndrome", longint'(out_syn), 8);
        chk(out_fixed == 1, "R5 second item fixed", longint'(out_fixed), 1);
        chk_vec("R5 second item data");
        @(negedge clk);
        chk(out_valid == 0, "R8 single transfer only", longint'(out_valid), 0);

        finish_run();
    end
endmodule